// File: doc/BRIEF.md
# Serial Flash Write-Enable and Status Front End

This block is the command front end of a serial flash device. It watches the serial clock, chip select and data-in lines and shifts in one instruction byte, most significant bit first. When chip select is released after a complete byte, it updates a write-enable flag and an auto-increment flag. On request it also streams an 8-bit status byte out on the data-out line. All of its logic runs on a fast system clock: the serial lines are synchronised and their edges are detected inside the block.

A program/erase engine sits beside the block. The engine reports its busy state, raises a request when it wants to start a write, and pulses a start signal when it enters auto-increment programming. The block grants a request only while writes are enabled and the engine is idle. A grant uses up the write-enable flag. A write-disable clears the flags but never stops an operation the engine is already running.

Top module: `spi_wen_ctrl`

## Requirements
- R1: Data-in is sampled on rising serial-clock edges, most significant bit first. Both clock polarities work: idle low (mode 0) and idle high (mode 3).
- R2: Opcode 0x06 sets the write-enable flag (status bit 1) when chip select rises after the 8th bit.
- R3: Opcode 0x04 clears both the write-enable flag and the auto-increment flag (status bit 6) when chip select rises. The busy bit (status bit 0) keeps following the engine.
- R4: Opcode 0x01 clears the write-enable flag when chip select rises after its 8th bit.
- R5: An opcode other than 0x06, 0x04, 0x01 and 0x35 has no effect on the flags. Neither does a byte cut short by chip select before its 8th bit.
- R6: Opcode 0x35 returns the status byte `{0, aai, 0, 0, 0, 0, wel, busy}` with bit 7 first. The first bit is launched on the first falling clock edge after the 8th bit. The byte repeats every 8 clocks for as long as chip select stays low.
- R7: The data-out enable is low while the opcode is being shifted in and whenever chip select is high.
- R8: An engine request is granted (one cycle later, one pulse) only if write-enable is 1 and busy is 0. A grant clears write-enable. The write-allowed output equals write-enable AND NOT busy.
- R9: An engine auto-increment start pulse sets the auto-increment flag.
- R10: After reset, write-enable, auto-increment, grant and the data-out enable are all 0.
- R11: Write-enable rises only on a committed chip-select release. It falls only on such a release or on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out (valid when enabled) |
| spi_so_oe | output | 1 | Output enable for data out; 0 means high impedance |
| eng_busy | input | 1 | Engine busy with a program/erase |
| eng_req | input | 1 | Engine request to start a write |
| eng_aai_start | input | 1 | Engine entered auto-increment mode |
| eng_grant | output | 1 | One-cycle grant of an engine request |
| wr_allowed | output | 1 | Writes currently allowed |

## Verification
The serial inputs pass through a two-stage synchroniser and an edge register. As a result, a flag change takes effect on the third system-clock edge after chip select rises, and a data-out bit settles three clocks after the serial falling edge that launches it. The grant appears one clock after the request. The bench holds each serial half-period for five system clocks and samples data out at the end of the low half. It waits eight clocks after releasing chip select before it reads any flag, and it checks the grant at the falling clock edge right after the request cycle. These sampling points always lie beyond each result's latency.

// File: rtl/spi_wen_pkg.sv
package spi_wen_pkg;

    localparam int OPW = 8;

    typedef logic [OPW-1:0] opcode_t;

    localparam opcode_t OP_SET_WE   = 8'h06;
    localparam opcode_t OP_CLR_WE   = 8'h04;
    localparam opcode_t OP_WR_STAT  = 8'h01;
    localparam opcode_t OP_RD_STAT  = 8'h35;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SET_WEL,
        CMD_CLR_ALL,
        CMD_CONSUME
    } cmd_e;

    typedef struct packed {
        logic aai;
        logic wel;
        logic busy;
    } flags_t;

    function automatic cmd_e decode_op(opcode_t op);
        case (op)
            OP_SET_WE:  return CMD_SET_WEL;
            OP_CLR_WE:  return CMD_CLR_ALL;
            OP_WR_STAT: return CMD_CONSUME;
            default:    return CMD_NONE;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(flags_t f);
        return {1'b0, f.aai, 4'b0000, f.wel, f.busy};
    endfunction

endpackage

// File: rtl/spi_wen_sync.sv
module spi_wen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_high,
    output logic si_s
);
    // each stage holds {sck, csn, si}
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] pipe [STAGES];
    logic       sck_d;
    logic       csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            pipe[0] <= {sck, csn, si};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_d <= pipe[STAGES-1][2];
            csn_d <= pipe[STAGES-1][1];
        end
    end

    assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
    assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
    assign cs_rise  = pipe[STAGES-1][1] & ~csn_d;
    assign cs_high  = pipe[STAGES-1][1];
    assign si_s     = pipe[STAGES-1][0];

endmodule

// File: rtl/spi_wen_rx.sv
module spi_wen_rx
    import spi_wen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_rise,
    input  logic    cs_high,
    input  logic    si_s,
    output opcode_t opcode,
    output logic    byte_done
);
    localparam int CW = $clog2(OPW + 1);

    logic [CW-1:0] cnt_q;
    opcode_t       sh_q;

    always_ff @(posedge clk) begin
        if (rst || cs_high) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (sck_rise && cnt_q != CW'(OPW)) begin
            sh_q  <= {sh_q[OPW-2:0], si_s};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign opcode    = sh_q;
    assign byte_done = (cnt_q == CW'(OPW));

endmodule

// File: rtl/spi_wen_tx.sv
module spi_wen_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_fall,
    input  logic       cs_high,
    input  logic       rd_sel,
    input  logic [7:0] status_now,
    output logic       so,
    output logic       so_oe
);
    logic [2:0] idx_q;
    logic [7:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst || cs_high) begin
            idx_q  <= 3'd7;
            snap_q <= '0;
            so     <= 1'b0;
            so_oe  <= 1'b0;
        end else if (sck_fall && rd_sel) begin
            so_oe <= 1'b1;
            if (idx_q == 3'd7) begin
                snap_q <= status_now;
                so     <= status_now[7];
            end else begin
                so     <= snap_q[idx_q];
            end
            idx_q <= idx_q - 3'd1;
        end
    end

endmodule

// File: rtl/spi_wen_latch.sv
module spi_wen_latch
    import spi_wen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  cmd_e cmd,
    input  logic eng_req,
    input  logic eng_busy,
    input  logic aai_start,
    output logic wel,
    output logic aai,
    output logic grant
);
    logic grant_now;
    assign grant_now = eng_req & wel & ~eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel   <= 1'b0;
            aai   <= 1'b0;
            grant <= 1'b0;
        end else begin
            grant <= grant_now;
            if (commit && cmd == CMD_SET_WEL) begin
                wel <= 1'b1;
            end else if (commit && (cmd == CMD_CLR_ALL || cmd == CMD_CONSUME)) begin
                wel <= 1'b0;
            end else if (grant_now) begin
                wel <= 1'b0;
            end
            if (commit && cmd == CMD_CLR_ALL) begin
                aai <= 1'b0;
            end else if (aai_start) begin
                aai <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_wen_ctrl.sv
module spi_wen_ctrl
    import spi_wen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe,
    input  logic eng_busy,
    input  logic eng_req,
    input  logic eng_aai_start,
    output logic eng_grant,
    output logic wr_allowed
);
    logic    sck_rise, sck_fall, cs_rise, cs_high, si_s;
    opcode_t opcode;
    logic    byte_done;
    logic    wel_q, aai_q;
    flags_t  flags;
    logic    commit;
    cmd_e    cmd;

    spi_wen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck(spi_sck), .csn(spi_csn), .si(spi_si),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_high(cs_high), .si_s(si_s)
    );

    spi_wen_rx u_rx (
        .clk(clk), .rst(rst),
        .sck_rise(sck_rise), .cs_high(cs_high), .si_s(si_s),
        .opcode(opcode), .byte_done(byte_done)
    );

    assign cmd    = decode_op(opcode);
    assign commit = cs_rise & byte_done;

    spi_wen_latch u_latch (
        .clk(clk), .rst(rst),
        .commit(commit), .cmd(cmd),
        .eng_req(eng_req), .eng_busy(eng_busy), .aai_start(eng_aai_start),
        .wel(wel_q), .aai(aai_q), .grant(eng_grant)
    );

    assign flags.aai  = aai_q;
    assign flags.wel  = wel_q;
    assign flags.busy = eng_busy;

    spi_wen_tx u_tx (
        .clk(clk), .rst(rst),
        .sck_fall(sck_fall), .cs_high(cs_high),
        .rd_sel(byte_done && opcode == OP_RD_STAT),
        .status_now(pack_status(flags)),
        .so(spi_so), .so_oe(spi_so_oe)
    );

    assign wr_allowed = wel_q & ~eng_busy;

endmodule

// File: rtl/spi_wen_ctrl_chk.sv
module spi_wen_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic spi_csn,
    input logic spi_so_oe,
    input logic eng_req,
    input logic eng_busy,
    input logic eng_grant,
    input logic wel,
    input logic aai,
    input logic cs_rise,
    input logic byte_done
);
    // R7: chip select high long enough to pass the synchroniser leaves data out disabled
    p_oe_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_so_oe);

    // R7: data out is enabled only once a whole opcode byte is in
    p_oe_after_byte_r7: assert property (@(posedge clk) disable iff (rst)
        spi_so_oe |-> byte_done);

    // R8: a grant only follows an eligible request
    p_grant_cond_r8: assert property (@(posedge clk) disable iff (rst)
        eng_grant |-> $past(eng_req && wel && !eng_busy));

    // R11 / R2: write-enable rises only on a committed release
    p_wel_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(cs_rise && byte_done));

    // R11 / R8: write-enable falls only on a commit or with a grant
    p_wel_fall_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> ($past(cs_rise && byte_done) || eng_grant));

    // R3: auto-increment clears only on a committed release
    p_aai_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(aai) |-> $past(cs_rise && byte_done));

endmodule

bind spi_wen_ctrl spi_wen_ctrl_chk u_chk (
    .clk(clk), .rst(rst),
    .spi_csn(spi_csn), .spi_so_oe(spi_so_oe),
    .eng_req(eng_req), .eng_busy(eng_busy), .eng_grant(eng_grant),
    .wel(wel_q), .aai(aai_q),
    .cs_rise(cs_rise), .byte_done(byte_done)
);

// File: tb/spi_wen_ctrl_tb.sv
module spi_wen_ctrl_tb;

    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_csn = 1'b1, spi_si = 1'b0;
    logic spi_so, spi_so_oe;
    logic eng_busy = 1'b0, eng_req = 1'b0, eng_aai_start = 1'b0;
    logic eng_grant, wr_allowed;

    int total = 0;
    int bad   = 0;

    bit m_wel = 1'b0, m_aai = 1'b0;

    always #5 clk = ~clk;

    spi_wen_ctrl u_dut (
        .clk(clk), .rst(rst),
        .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .eng_busy(eng_busy), .eng_req(eng_req), .eng_aai_start(eng_aai_start),
        .eng_grant(eng_grant), .wr_allowed(wr_allowed)
    );

    function automatic logic [7:0] exp_status(bit w, bit a, bit b);
        return {1'b0, a, 4'b0000, w, b};
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits of op, then read nread bits; returns read bits and oe errors.
    task automatic spi_xfer(input logic [7:0] op, input int nbits, input bit mode3,
                            input int nread, output logic [15:0] rd, output bit oe_bad);
        rd = '0;
        oe_bad = 1'b0;
        @(negedge clk);
        spi_sck = mode3;
        wait_clk(2);
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sck = 1'b0;
            spi_si  = op[7-i];
            wait_clk(HALF);
            spi_sck = 1'b1;
            wait_clk(HALF);
            if (spi_so_oe) oe_bad = 1'b1;
        end
        for (int i = 0; i < nread; i++) begin
            spi_sck = 1'b0;
            wait_clk(HALF);
            rd = {rd[14:0], spi_so};
            if (!spi_so_oe) oe_bad = 1'b1;
            spi_sck = 1'b1;
            wait_clk(HALF);
        end
        if (!mode3) begin
            spi_sck = 1'b0;
            wait_clk(HALF);
        end
        spi_csn = 1'b1;
        wait_clk(8);
        if (spi_so_oe) oe_bad = 1'b1;
    endtask

    task automatic send_op(logic [7:0] op, int nbits, bit mode3, string req);
        logic [15:0] rd;
        bit ob;
        spi_xfer(op, nbits, mode3, 0, rd, ob);
        chk(!ob, {req, " R7 oe"}, {15'd0, ob}, 16'd0);
        if (nbits == 8) begin
            case (op)
                8'h06: m_wel = 1'b1;
                8'h04: begin m_wel = 1'b0; m_aai = 1'b0; end
                8'h01: m_wel = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic read_status(bit mode3, string req);
        logic [15:0] rd;
        logic [7:0] e;
        bit ob;
        e = exp_status(m_wel, m_aai, eng_busy);
        spi_xfer(8'h35, 8, mode3, 16, rd, ob);
        chk(rd == {e, e}, {req, " R6 R1 status"}, rd, {e, e});
        chk(!ob, {req, " R7 oe"}, {15'd0, ob}, 16'd0);
        chk(wr_allowed == (m_wel && !eng_busy), {req, " R8 wr_allowed"},
            {15'd0, wr_allowed}, {15'd0, (m_wel && !eng_busy)});
    endtask

    task automatic pulse_req(string req);
        bit e;
        e = m_wel && !eng_busy;
        @(negedge clk);
        eng_req = 1'b1;
        @(negedge clk);
        eng_req = 1'b0;
        chk(eng_grant == e, {req, " R8 grant"}, {15'd0, eng_grant}, {15'd0, e});
        @(negedge clk);
        chk(eng_grant == 1'b0, {req, " R8 grant pulse"}, {15'd0, eng_grant}, 16'd0);
        if (e) m_wel = 1'b0;
    endtask

    task automatic pulse_aai();
        @(negedge clk);
        eng_aai_start = 1'b1;
        @(negedge clk);
        eng_aai_start = 1'b0;
        m_aai = 1'b1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] op;
        void'($urandom(32'd4711));
        wait_clk(5);
        // R10: reset state
        chk(spi_so_oe == 1'b0, "R10 oe", {15'd0, spi_so_oe}, 16'd0);
        chk(eng_grant == 1'b0, "R10 grant", {15'd0, eng_grant}, 16'd0);
        rst = 1'b0;
        wait_clk(4);
        chk(wr_allowed == 1'b0, "R10 wr_allowed", {15'd0, wr_allowed}, 16'd0);
        read_status(1'b0, "R10");

        // R2 in mode 0 and R1 in mode 3
        send_op(8'h06, 8, 1'b0, "R2");
        read_status(1'b0, "R2");
        send_op(8'h04, 8, 1'b1, "R3");
        send_op(8'h06, 8, 1'b1, "R1");
        read_status(1'b1, "R1");

        // R9 then R3 clears both flags
        pulse_aai();
        read_status(1'b0, "R9");
        send_op(8'h04, 8, 1'b1, "R3");
        read_status(1'b1, "R3");

        // R3 with engine busy: busy still reported
        send_op(8'h06, 8, 1'b0, "R3");
        eng_busy = 1'b1;
        pulse_aai();
        send_op(8'h04, 8, 1'b0, "R3");
        read_status(1'b0, "R3 busy");
        eng_busy = 1'b0;

        // R4 consumes write-enable
        send_op(8'h06, 8, 1'b0, "R4");
        send_op(8'h01, 8, 1'b1, "R4");
        read_status(1'b0, "R4");

        // R5 unknown opcode and partial byte ignored
        send_op(8'h06, 8, 1'b0, "R5");
        send_op(8'hA5, 8, 1'b0, "R5");
        read_status(1'b1, "R5 unknown");
        send_op(8'h04, 7, 1'b0, "R5");
        read_status(1'b0, "R5 partial");
        send_op(8'h01, 3, 1'b1, "R5");
        read_status(1'b1, "R5 partial m3");

        // R8 grant blocked by busy, then granted
        eng_busy = 1'b1;
        pulse_req("R8 busy");
        read_status(1'b0, "R8 busy");
        eng_busy = 1'b0;
        pulse_req("R8 idle");
        read_status(1'b0, "R8 consumed");
        pulse_req("R8 no wel");

        // random mix
        for (int n = 0; n < 90; n++) begin
            int kind;
            bit m3;
            kind = $urandom % 7;
            m3   = $urandom % 2;
            eng_busy = ($urandom % 4) == 0;
            wait_clk(2);
            case (kind)
                0: send_op(8'h06, 8, m3, "R2 rnd");
                1: send_op(8'h04, 8, m3, "R3 rnd");
                2: send_op(8'h01, 8, m3, "R4 rnd");
                3: read_status(m3, "R6 rnd");
                4: begin
                    op = 8'($urandom);
                    if (op == 8'h06 || op == 8'h04 || op == 8'h01 || op == 8'h35) op = 8'hFF;
                    send_op(op, 8, m3, "R5 rnd");
                end
                5: send_op(8'($urandom), 1 + ($urandom % 7), m3, "R5 rnd partial");
                default: begin
                    if ($urandom % 2) pulse_aai();
                    pulse_req("R8 rnd");
                end
            endcase
            read_status($urandom % 2, "R11 rnd");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule